// File: doc/BRIEF.md
# Dual-Mode Counter/Timer

This block is a 16-bit programmable counter/timer for a serial controller. A CPU loads a preload value through two byte-wide write strobes, one for the high byte and one for the low byte. A single-cycle start strobe and a single-cycle stop strobe control the count. A clock-enable pulse, the timing source, advances the count by one step.

In timer mode the unit runs continuously and produces a square wave. That wave can serve as a 16X baud clock, which gives a bit rate of the source rate divided by 32 × preload. It can also act as a periodic interrupt source. In counter mode the unit counts down once from the preload and flags terminal count on its output pin and its ready flag. The interrupt request is the ready flag gated by a mask input.

Top module: `ctmr_unit`

## Requirements
- R1: After reset `wave_out` is 1, `ready` and `irq` are 0, and nothing counts: timing pulses arrive with no start and leave the outputs unchanged.
- R2: In timer mode (`mode_counter`=0) a start sets `wave_out` to 1. The wave then toggles after every P timing pulses, where P = high byte × 256 + low byte. Cycles without `tick_en` do not advance the count.
- R3: A preload of 0 gives a half-period of 65536 timing pulses.
- R4: In timer mode, preload writes made during a half-period leave that half-period's length unchanged. The new value applies from the next half-period.
- R5: A start strobe aborts any cycle in progress and begins a new one from the current registers, with `wave_out`=1 and `ready` cleared. A timing pulse in the same cycle is ignored.
- R6: In timer mode `ready` is set on each rising edge of `wave_out` that ends a full period. It stays set until a start or stop strobe.
- R7: In timer mode a stop strobe clears `ready` but does not halt or disturb the square wave.
- R8: In counter mode (`mode_counter`=1) a start loads P with `wave_out`=1 and `ready`=0. After P timing pulses `wave_out` goes to 0 and `ready` to 1.
- R9: Past terminal count the counter keeps counting down through 0xFFFF. `wave_out` stays 0 and `ready` stays 1 until a stop.
- R10: In counter mode a stop strobe halts the count, returns `wave_out` to 1 and clears `ready`. Later timing pulses have no effect.
- R11: In counter mode, preload writes have no effect on a run in progress. The next start uses the current registers, and unchanged registers are reused.
- R12: `irq` is 1 exactly when `ready` is 1 and `irq_mask` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timing-source pulse, one count step |
| mode_counter | input | 1 | 0 = timer (square wave), 1 = one-shot counter |
| wr_hi | input | 1 | Write strobe for the preload high byte |
| wr_lo | input | 1 | Write strobe for the preload low byte |
| wr_data | input | 8 | Byte written by wr_hi or wr_lo |
| start_stb | input | 1 | Start/restart strobe |
| stop_stb | input | 1 | Stop strobe |
| irq_mask | input | 1 | Interrupt enable for the ready flag |
| wave_out | output | 1 | Square wave or terminal-count pin |
| ready | output | 1 | Ready status flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench rewrites the preload in the middle of a timer half-period. A design that reloads on every write would shorten or stretch that half-period. It also issues a stop to the running timer, where a design that halts the wave would freeze `wave_out`. It runs a zero preload for a full 65536 pulses, where an unguarded design would toggle at once or never. In counter mode it counts past terminal count, rewrites the registers mid-run and restarts both mid-run and after terminal count. A design that wrapped the pin back high, used the new value early or lost the old value on a restart would show a wrong pin or flag.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
   typedef enum logic {
      CT_TIMER   = 1'b0,
      CT_COUNTER = 1'b1
   } ct_mode_e;
endpackage

// File: rtl/ctmr_preload.sv
module ctmr_preload #(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [CNT_W-1:0]  preload
);
   logic [BYTE_W-1:0] hi_q, lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         if (wr_hi) hi_q <= wr_data;
         if (wr_lo) lo_q <= wr_data;
      end
   end

   assign preload = {hi_q, lo_q};
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
   import ctmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ct_mode_e         mode,
   input  logic             tick,
   input  logic             start,
   input  logic             stop,
   input  logic [CNT_W-1:0] preload,
   output logic             wave,
   output logic             done_ev,
   output logic [CNT_W-1:0] cnt,
   output logic             running
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             run_q, run_d;
   logic             wave_q, wave_d;
   logic             halt_req, step, term;

   // stop only halts in counter mode; start outranks stop
   assign halt_req = stop && (mode == CT_COUNTER) && !start;
   assign step     = run_q && tick && !start && !halt_req;
   assign term     = step && (cnt_q == LAST);

   always_comb begin
      cnt_d  = cnt_q;
      run_d  = run_q;
      wave_d = wave_q;
      if (start) begin
         cnt_d  = preload;
         run_d  = 1'b1;
         wave_d = 1'b1;
      end else if (halt_req) begin
         run_d  = 1'b0;
         wave_d = 1'b1;
      end else if (term) begin
         if (mode == CT_TIMER) begin
            cnt_d  = preload;          // half-period boundary picks up new value
            wave_d = ~wave_q;
         end else begin
            cnt_d  = cnt_q - LAST;     // reaches zero, keeps wrapping afterwards
            wave_d = 1'b0;
         end
      end else if (step) begin
         cnt_d = cnt_q - LAST;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         run_q  <= 1'b0;
         wave_q <= 1'b1;
      end else begin
         cnt_q  <= cnt_d;
         run_q  <= run_d;
         wave_q <= wave_d;
      end
   end

   // timer: end of a low half = end of a full period
   assign done_ev = term && ((mode == CT_COUNTER) || !wave_q);
   assign wave    = wave_q;
   assign cnt     = cnt_q;
   assign running = run_q;
endmodule

// File: rtl/ctmr_flag.sv
module ctmr_flag #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr_ev,
   input  logic mask,
   output logic ready,
   output logic irq
);
   logic ready_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       ready_q <= 1'b0;
      else if (clr_ev)  ready_q <= 1'b0;
      else if (set_ev)  ready_q <= 1'b1;
   end

   assign ready = ready_q;

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= ready_q & mask;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = ready_q & mask;
      end
   endgenerate
endmodule

// File: rtl/ctmr_unit.sv
module ctmr_unit
   import ctmr_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int CNT_W   = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              mode_counter,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              start_stb,
   input  logic              stop_stb,
   input  logic              irq_mask,
   output logic              wave_out,
   output logic              ready,
   output logic              irq
);
   generate
      if (CNT_W != 2 * BYTE_W) begin : g_bad_width
         $error("ctmr_unit: CNT_W must be twice BYTE_W");
      end
      if (BYTE_W < 2) begin : g_bad_byte
         $error("ctmr_unit: BYTE_W too small");
      end
   endgenerate

   ct_mode_e         mode_w;
   logic [CNT_W-1:0] preload_w;
   logic [CNT_W-1:0] count_w;
   logic             run_w;
   logic             done_w;

   assign mode_w = mode_counter ? CT_COUNTER : CT_TIMER;

   ctmr_preload #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi   (wr_hi),
      .wr_lo   (wr_lo),
      .wr_data (wr_data),
      .preload (preload_w)
   );

   ctmr_core #(.CNT_W(CNT_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode_w),
      .tick    (tick_en),
      .start   (start_stb),
      .stop    (stop_stb),
      .preload (preload_w),
      .wave    (wave_out),
      .done_ev (done_w),
      .cnt     (count_w),
      .running (run_w)
   );

   ctmr_flag #(.IRQ_REG(IRQ_REG)) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (done_w),
      .clr_ev (start_stb | stop_stb),
      .mask   (irq_mask),
      .ready  (ready),
      .irq    (irq)
   );
endmodule

// File: rtl/ctmr_unit_chk.sv
module ctmr_unit_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_i,
   input logic             tick_i,
   input logic             start_i,
   input logic             stop_i,
   input logic             mask_i,
   input logic             wave_i,
   input logic             ready_i,
   input logic             irq_i,
   input logic [CNT_W-1:0] cnt_i,
   input logic             run_i
);
   a_r12_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_i |-> !irq_i);

   a_r5_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (wave_i && !ready_i && run_i));

   a_r10_counter_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i && mode_i) |=> (wave_i && !ready_i && !run_i));

   a_r7_timer_stop_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i && !mode_i && run_i) |=> (run_i && !ready_i));

   a_r2_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !start_i && !stop_i) |=> ($stable(cnt_i) && $stable(wave_i)));

   a_r8_terminal_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i && run_i && tick_i && !start_i && !stop_i && cnt_i == CNT_W'(1))
      |=> (!wave_i && ready_i));

   a_r9_wraps_past_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i && run_i && tick_i && !start_i && !stop_i && cnt_i == '0)
      |=> (cnt_i == '1));

   a_r9_pin_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i && run_i && !wave_i && !start_i && !stop_i) |=> !wave_i);
endmodule

bind ctmr_unit ctmr_unit_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode_i  (mode_counter),
   .tick_i  (tick_en),
   .start_i (start_stb),
   .stop_i  (stop_stb),
   .mask_i  (irq_mask),
   .wave_i  (wave_out),
   .ready_i (ready),
   .irq_i   (irq),
   .cnt_i   (count_w),
   .run_i   (run_w)
);

// File: tb/ctmr_unit_test.sv
module ctmr_unit_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, mode = 1'b0, wh = 1'b0, wl = 1'b0;
   logic       st = 1'b0, sp = 1'b0, mask = 1'b1;
   logic [7:0] d = '0;
   logic       wave, rdy, irq;

   int errors = 0;
   int checks = 0;

   typedef struct {
      bit    w;
      bit    r;
      bit    i;
      string req;
   } exp_t;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ctmr_unit uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick), .mode_counter(mode),
      .wr_hi(wh), .wr_lo(wl), .wr_data(d), .start_stb(st), .stop_stb(sp),
      .irq_mask(mask), .wave_out(wave), .ready(rdy), .irq(irq)
   );

   function automatic bit wf(int k, int p);
      return ((k / p) % 2) == 0;
   endfunction

   task automatic check_now(bit ew, bit er, bit ei, string req);
      checks++;
      if (wave !== ew || rdy !== er || irq !== ei) begin
         errors++;
         $display("FAIL %s: wave/ready/irq=%b%b%b expected %b%b%b",
                  req, wave, rdy, irq, ew, er, ei);
      end
   endtask

   // driver: applies one cycle of stimulus, queues the expected result
   task automatic drv(bit tk, bit st_, bit sp_, bit wh_, bit wl_, logic [7:0] d_,
                      bit chk, bit ew, bit er, string req);
      tick = tk; st = st_; sp = sp_; wh = wh_; wl = wl_; d = d_;
      if (chk) q.push_back('{ew, er, er & mask, req});
      @(negedge clk);
      tick = 0; st = 0; sp = 0; wh = 0; wl = 0;
   endtask

   task automatic tk(bit ew, bit er, string req);
      drv(1, 0, 0, 0, 0, 8'h00, 1, ew, er, req);
   endtask

   task automatic wr_pre(logic [15:0] v, bit ew, bit er, string req);
      drv(0, 0, 0, 1, 0, v[15:8], 1, ew, er, req);
      drv(0, 0, 0, 0, 1, v[7:0], 1, ew, er, req);
   endtask

   // monitor: compares outputs shortly after each edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check_now(e.w, e.r, e.i, e.req);
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_now(1, 0, 0, "R1");
      // R1: ticks with no start change nothing
      for (int k = 0; k < 3; k++) tk(1, 0, "R1");

      // ---- timer, P=3 ----
      mode = 0; mask = 1;
      wr_pre(16'd3, 1, 0, "R1");
      drv(0, 1, 0, 0, 0, 8'h00, 1, 1, 0, "R5");
      for (int k = 1; k <= 12; k++) tk(wf(k, 3), k >= 6, (k < 6) ? "R2" : "R6");
      // R7: stop keeps the wave running, clears ready
      drv(1, 0, 1, 0, 0, 8'h00, 1, wf(13, 3), 0, "R7");
      for (int k = 14; k <= 18; k++) tk(wf(k, 3), k >= 18, "R7");
      // R2: gapped ticks
      for (int k = 19; k <= 24; k++) begin
         drv(0, 0, 0, 0, 0, 8'h00, 1, wf(k - 1, 3), 1, "R2");
         tk(wf(k, 3), 1, "R2");
      end

      // ---- R4: write mid half-period ----
      tk(1, 1, "R4");                       // k=25
      wr_pre(16'd5, 1, 1, "R4");
      tk(1, 1, "R4");                       // k=26
      tk(0, 1, "R4");                       // k=27, old half length kept
      for (int j = 1; j <= 10; j++) tk((j >= 5 && j < 10), 1, "R4");

      // ---- R5: start aborts with new value ----
      wr_pre(16'd2, 0, 1, "R5");
      drv(1, 1, 0, 0, 0, 8'h00, 1, 1, 0, "R5");
      tk(1, 0, "R5");
      tk(0, 0, "R5");
      tk(0, 0, "R5");
      tk(1, 1, "R5");

      // ---- R3: zero preload ----
      wr_pre(16'd0, 1, 1, "R3");
      drv(0, 1, 0, 0, 0, 8'h00, 1, 1, 0, "R3");
      for (int i = 1; i <= 65535; i++)
         drv(1, 0, 0, 0, 0, 8'h00, i == 65535, 1, 0, "R3");
      tk(0, 0, "R3");

      // ---- counter mode ----
      mode = 1;
      drv(0, 0, 1, 0, 0, 8'h00, 1, 1, 0, "R10");
      for (int k = 0; k < 3; k++) tk(1, 0, "R10");
      wr_pre(16'd4, 1, 0, "R8");
      drv(0, 1, 0, 0, 0, 8'h00, 1, 1, 0, "R8");
      tk(1, 0, "R8");
      wr_pre(16'd2, 1, 0, "R11");           // must not affect this run
      tk(1, 0, "R11");
      tk(1, 0, "R11");
      tk(0, 1, "R8");
      mask = 0;
      for (int k = 0; k < 4; k++) tk(0, 1, "R9");
      tk(0, 1, "R12");
      mask = 1;
      tk(0, 1, "R12");
      drv(0, 0, 1, 0, 0, 8'h00, 1, 1, 0, "R10");
      for (int k = 0; k < 3; k++) tk(1, 0, "R10");
      // R11: new value used at next start, then reused
      drv(0, 1, 0, 0, 0, 8'h00, 1, 1, 0, "R11");
      tk(1, 0, "R11");
      tk(0, 1, "R11");
      tk(0, 1, "R9");
      drv(0, 1, 0, 0, 0, 8'h00, 1, 1, 0, "R11");
      tk(1, 0, "R11");
      tk(0, 1, "R11");
      // restart mid-run
      drv(0, 1, 0, 0, 0, 8'h00, 1, 1, 0, "R11");
      tk(1, 0, "R11");
      drv(0, 1, 0, 0, 0, 8'h00, 1, 1, 0, "R11");
      tk(1, 0, "R11");
      tk(0, 1, "R11");
      // stop before terminal count
      drv(0, 1, 0, 0, 0, 8'h00, 1, 1, 0, "R10");
      tk(1, 0, "R10");
      drv(0, 0, 1, 0, 0, 8'h00, 1, 1, 0, "R10");
      for (int k = 0; k < 3; k++) tk(1, 0, "R10");

      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule